// File: doc/BRIEF.md
# Scoreboard Function Unit Issue Controller

This block sits beside one function unit of a scoreboard-scheduled core and governs when that unit may read its operands. An instruction is handed to it together with the register tag of each source operand and a mask that says which of those registers still await a write from another unit. The controller keeps one availability flag per operand. It then watches the shared result broadcast bus. A broadcast whose destination tag equals a waiting operand's tag marks that operand available.

Once every operand is available, the controller raises a read request toward the central picker. In the cycle in which the picker grants the read, the controller places the held source tags on the register-file read-index lines. In that same cycle it pulses a capture strobe, so the attached computation unit latches the read data. The controller then waits in an execute state until the unit reports completion. A flush abandons the held instruction from any state.

Top module: `fu_issue_ctrl`

## Requirements
- R1: After reset the block is idle: `issue_ready` is 1, and `rd_req`, `cap_strobe` and `rf_src_idx` are 0.
- R2: An issue is taken only while `issue_ready` is 1. An `issue_valid` at any other time does not change the held tags, which later appear at the read indices.
- R3: An operand whose `issue_src_pending` bit is 0 at issue counts as available at once. With a zero mask, `rd_req` is 1 in the cycle after the issue edge.
- R4: A broadcast with `bcast_valid` 1 and `bcast_tag` equal to a waiting operand's tag marks that operand available. A different tag, or `bcast_valid` 0, has no effect.
- R5: `rd_req` is 1 only when every operand of the held instruction is available. After the last needed broadcast edge it rises in the next cycle.
- R6: A matching broadcast in the same cycle as the issue counts for the operands of that issue.
- R7: In a grant cycle (`rd_req` 1 and `go_read` 1), `cap_strobe` is 1 and `rf_src_idx` carries the tag of operand i in bits [i*TAG_W +: TAG_W]. Outside a grant cycle both are 0.
- R8: After a grant, `rd_req` is 0 in the following cycle, so one grant yields exactly one capture. A `go_read` without a pending request has no effect.
- R9: In the execute state, `exec_done` returns the block to idle, and `issue_ready` is 1 in the next cycle.
- R10: `flush` returns the block to idle in the next cycle from any state. A flush in a grant cycle suppresses `cap_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Abandon the held instruction |
| issue_valid | input | 1 | Issue of a new instruction |
| issue_src_tags | input | NUM_SRC*TAG_W | Source register tags, operand i at [i*TAG_W +: TAG_W] |
| issue_src_pending | input | NUM_SRC | Bit i set: operand i's register awaits a write |
| issue_ready | output | 1 | Controller is idle and accepts an issue |
| bcast_valid | input | 1 | A result is being broadcast |
| bcast_tag | input | TAG_W | Destination register tag of the broadcast |
| rd_req | output | 1 | Read request to the picker |
| go_read | input | 1 | Read grant from the picker |
| rf_src_idx | output | NUM_SRC*TAG_W | Register-file read indices during a grant |
| cap_strobe | output | 1 | Capture operand values this cycle |
| exec_done | input | 1 | Computation unit finished |

## Verification
Two functions can coincide in one cycle. An issue can arrive with a broadcast that already carries one of its pending tags, and a grant can arrive together with a flush. The bench drives the first by asserting `issue_valid` and a matching `bcast_valid` on the same edge. It passes if `rd_req` rises in the very next cycle and no further broadcast is needed. It drives the second by raising `go_read` and `flush` together. It passes if no capture strobe appears in that cycle and the block is ready for a new issue one cycle later.

// File: rtl/fu_issue_pkg.sv
package fu_issue_pkg;

    localparam int unsigned DEF_NUM_SRC = 2;
    localparam int unsigned DEF_TAG_W   = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_READ = 2'd2,
        ST_EXEC = 2'd3
    } fu_state_e;

    function automatic logic tag_hit(input logic valid, input logic [31:0] a, input logic [31:0] b);
        return valid && (a == b);
    endfunction

endpackage

// File: rtl/fu_operand_tracker.sv
module fu_operand_tracker
    import fu_issue_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned TAG_W   = DEF_TAG_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [NUM_SRC*TAG_W-1:0] in_tags,
    input  logic [NUM_SRC-1:0]       in_pending,
    input  logic                     bc_valid,
    input  logic [TAG_W-1:0]         bc_tag,
    output logic [NUM_SRC*TAG_W-1:0] held_tags,
    output logic [NUM_SRC-1:0]       avail,
    output logic                     all_avail_next
);
    localparam int unsigned VEC_W = NUM_SRC * TAG_W;

    logic [NUM_SRC-1:0] avail_d;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
        logic [TAG_W-1:0] new_tag;
        logic [TAG_W-1:0] old_tag;
        assign new_tag = in_tags[i*TAG_W +: TAG_W];
        assign old_tag = held_tags[i*TAG_W +: TAG_W];
        always_comb begin
            if (load)
                avail_d[i] = !in_pending[i] || tag_hit(bc_valid, 32'(new_tag), 32'(bc_tag));
            else
                avail_d[i] = avail[i] || tag_hit(bc_valid, 32'(old_tag), 32'(bc_tag));
        end
    end

    assign all_avail_next = &avail_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_tags <= '0;
            avail     <= '0;
        end else begin
            avail <= avail_d;
            if (load) held_tags <= in_tags;
        end
    end

    // Held tags only move on an accepted issue (R2)
    p_tags_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held_tags));
    // Availability is sticky between issues (R4)
    p_avail_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((avail & $past(avail)) == $past(avail)));

    logic [VEC_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/fu_issue_fsm.sv
module fu_issue_fsm
    import fu_issue_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      issue_valid,
    input  logic      ops_ready_next,
    input  logic      go_read,
    input  logic      exec_done,
    output fu_state_e state,
    output logic      load
);
    fu_state_e state_d;

    assign load = (state == ST_IDLE) && issue_valid && !flush;

    always_comb begin
        state_d = state;
        if (flush) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (issue_valid) state_d = ops_ready_next ? ST_READ : ST_WAIT;
                ST_WAIT: if (ops_ready_next) state_d = ST_READ;
                ST_READ: if (go_read) state_d = ST_EXEC;
                ST_EXEC: if (exec_done) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    p_flush_idle_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (state == ST_IDLE));
    p_grant_leaves_read_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ && go_read && !flush) |=> (state == ST_EXEC));
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && exec_done && !flush) |=> (state == ST_IDLE));
endmodule

// File: rtl/fu_read_port.sv
module fu_read_port
    import fu_issue_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned TAG_W   = DEF_TAG_W
) (
    input  fu_state_e                state,
    input  logic                     go_read,
    input  logic                     flush,
    input  logic [NUM_SRC*TAG_W-1:0] held_tags,
    output logic [NUM_SRC*TAG_W-1:0] rf_src_idx,
    output logic                     cap_strobe
);
    logic grant;
    assign grant      = (state == ST_READ) && go_read && !flush;
    assign cap_strobe = grant;
    assign rf_src_idx = grant ? held_tags : '0;
endmodule

// File: rtl/fu_issue_ctrl.sv
module fu_issue_ctrl
    import fu_issue_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned TAG_W   = DEF_TAG_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     issue_valid,
    input  logic [NUM_SRC*TAG_W-1:0] issue_src_tags,
    input  logic [NUM_SRC-1:0]       issue_src_pending,
    output logic                     issue_ready,
    input  logic                     bcast_valid,
    input  logic [TAG_W-1:0]         bcast_tag,
    output logic                     rd_req,
    input  logic                     go_read,
    output logic [NUM_SRC*TAG_W-1:0] rf_src_idx,
    output logic                     cap_strobe,
    input  logic                     exec_done
);
    fu_state_e                state;
    logic                     load;
    logic                     ready_next;
    logic [NUM_SRC-1:0]       avail;
    logic [NUM_SRC*TAG_W-1:0] held_tags;

    fu_operand_tracker #(.NUM_SRC(NUM_SRC), .TAG_W(TAG_W)) u_track (
        .clk(clk), .rst(rst), .load(load),
        .in_tags(issue_src_tags), .in_pending(issue_src_pending),
        .bc_valid(bcast_valid), .bc_tag(bcast_tag),
        .held_tags(held_tags), .avail(avail), .all_avail_next(ready_next)
    );

    fu_issue_fsm u_fsm (
        .clk(clk), .rst(rst), .flush(flush), .issue_valid(issue_valid),
        .ops_ready_next(ready_next), .go_read(go_read), .exec_done(exec_done),
        .state(state), .load(load)
    );

    fu_read_port #(.NUM_SRC(NUM_SRC), .TAG_W(TAG_W)) u_rd (
        .state(state), .go_read(go_read), .flush(flush), .held_tags(held_tags),
        .rf_src_idx(rf_src_idx), .cap_strobe(cap_strobe)
    );

    assign issue_ready = (state == ST_IDLE);
    assign rd_req      = (state == ST_READ);

    // Request only with every operand flag set (R5)
    p_req_needs_ops_r5: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (&avail));
    // Strobe only while requesting (R7)
    p_strobe_in_req_r7: assert property (@(posedge clk) disable iff (rst)
        cap_strobe |-> rd_req);
    // One capture per grant (R8)
    p_single_capture_r8: assert property (@(posedge clk) disable iff (rst)
        cap_strobe |=> !cap_strobe);
    // Accepted issue leaves idle (R2)
    p_issue_leaves_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (issue_ready && issue_valid && !flush) |=> !issue_ready);
endmodule

// File: tb/fu_issue_ctrl_test.sv
module fu_issue_ctrl_test;
    localparam int NS = 2;
    localparam int TW = 5;

    typedef struct packed {
        logic [TW-1:0] t0;
        logic [TW-1:0] t1;
        logic [1:0]    pend;
        logic [TW-1:0] noise;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{t0: 5'd3,  t1: 5'd7,  pend: 2'b00, noise: 5'd9},
        '{t0: 5'd3,  t1: 5'd7,  pend: 2'b01, noise: 5'd9},
        '{t0: 5'd3,  t1: 5'd7,  pend: 2'b10, noise: 5'd3},
        '{t0: 5'd12, t1: 5'd12, pend: 2'b11, noise: 5'd1},
        '{t0: 5'd31, t1: 5'd0,  pend: 2'b11, noise: 5'd30},
        '{t0: 5'd5,  t1: 5'd6,  pend: 2'b11, noise: 5'd6}
    };

    logic clk = 0, rst = 1, flush = 0, issue_valid = 0, bcast_valid = 0, go_read = 0, exec_done = 0;
    logic [NS*TW-1:0] issue_src_tags = '0;
    logic [NS-1:0] issue_src_pending = '0;
    logic [TW-1:0] bcast_tag = '0;
    logic issue_ready, rd_req, cap_strobe;
    logic [NS*TW-1:0] rf_src_idx;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fu_issue_ctrl #(.NUM_SRC(NS), .TAG_W(TW)) uut (
        .clk(clk), .rst(rst), .flush(flush), .issue_valid(issue_valid),
        .issue_src_tags(issue_src_tags), .issue_src_pending(issue_src_pending),
        .issue_ready(issue_ready), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .rd_req(rd_req), .go_read(go_read), .rf_src_idx(rf_src_idx),
        .cap_strobe(cap_strobe), .exec_done(exec_done)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_issue(input logic [TW-1:0] a, input logic [TW-1:0] b, input logic [1:0] p);
        issue_valid = 1; issue_src_tags = {b, a}; issue_src_pending = p;
        tick();
        issue_valid = 0;
    endtask

    task automatic do_bcast(input logic [TW-1:0] t);
        bcast_valid = 1; bcast_tag = t;
        tick();
        bcast_valid = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] ready;
        @(negedge clk); tick(); tick();
        rst = 0;
        // R1 reset state
        check("R1 issue_ready", 32'(issue_ready), 1);
        check("R1 rd_req", 32'(rd_req), 0);
        check("R1 cap_strobe", 32'(cap_strobe), 0);
        check("R1 rf_src_idx", 32'(rf_src_idx), 0);

        foreach (TBL[k]) begin
            vec_t v = TBL[k];
            ready = ~v.pend;
            do_issue(v.t0, v.t1, v.pend);
            check("R3 rd_req after issue", 32'(rd_req), 32'(&ready));
            do_bcast(v.noise);
            if (v.noise == v.t0) ready[0] = 1'b1;
            if (v.noise == v.t1) ready[1] = 1'b1;
            check("R4 rd_req after other tag", 32'(rd_req), 32'(&ready));
            do_bcast(v.t0);
            ready[0] = 1'b1;
            if (v.t0 == v.t1) ready[1] = 1'b1;
            check("R5 rd_req after first tag", 32'(rd_req), 32'(&ready));
            do_bcast(v.t1);
            check("R5 rd_req all ready", 32'(rd_req), 1);
            check("R7 no strobe before grant", 32'(cap_strobe), 0);
            go_read = 1; #1;
            check("R7 strobe in grant", 32'(cap_strobe), 1);
            check("R7 indices in grant", 32'(rf_src_idx), 32'({v.t1, v.t0}));
            tick();
            go_read = 0; #1;
            check("R8 rd_req after grant", 32'(rd_req), 0);
            check("R7 indices after grant", 32'(rf_src_idx), 0);
            exec_done = 1;
            tick();
            exec_done = 0;
            check("R9 ready after done", 32'(issue_ready), 1);
        end

        // R6: broadcast together with the issue
        issue_valid = 1; issue_src_tags = {5'd8, 5'd4}; issue_src_pending = 2'b01;
        bcast_valid = 1; bcast_tag = 5'd4;
        tick();
        issue_valid = 0; bcast_valid = 0;
        check("R6 same-cycle broadcast", 32'(rd_req), 1);
        // R2: issue while busy is ignored
        do_issue(5'd20, 5'd21, 2'b00);
        check("R2 busy not ready", 32'(issue_ready), 0);
        go_read = 1; #1;
        check("R2 original tags kept", 32'(rf_src_idx), 32'({5'd8, 5'd4}));
        tick(); go_read = 0;
        exec_done = 1; tick(); exec_done = 0;

        // R8 and R4: grant without request, disabled broadcast
        do_issue(5'd10, 5'd11, 2'b11);
        go_read = 1; #1;
        check("R8 no strobe without request", 32'(cap_strobe), 0);
        check("R8 no indices without request", 32'(rf_src_idx), 0);
        tick(); go_read = 0;
        bcast_valid = 0; bcast_tag = 5'd10; tick();
        do_bcast(5'd11);
        check("R4 invalid broadcast ignored", 32'(rd_req), 0);
        // R10: flush while waiting
        flush = 1; tick(); flush = 0;
        check("R10 flush from wait", 32'(issue_ready), 1);

        // R10: flush during grant
        do_issue(5'd1, 5'd2, 2'b00);
        check("R3 ready request", 32'(rd_req), 1);
        go_read = 1; flush = 1; #1;
        check("R10 strobe suppressed", 32'(cap_strobe), 0);
        tick(); go_read = 0; flush = 0;
        check("R10 idle after flush", 32'(issue_ready), 1);
        check("R10 no request after flush", 32'(rd_req), 0);

        finish_run();
    end
endmodule